// File: doc/BRIEF.md
# Pseudo-SRAM Single-Access Sequencer

This block sits between a synchronous request port and an external pseudo-SRAM that behaves like an asynchronous SRAM: a 20-bit address, a 16-bit bidirectional data bus, and active-low select, write strobe, output strobe and two byte strobes. Each accepted request becomes exactly one memory cycle. A read holds the output strobe low and samples the bus once the worst-case access time has elapsed. A write holds the write strobe low and drives the bus for the whole active phase. Every phase length is a count of clock cycles set by a parameter.

The memory core is built from DRAM cells and refreshes itself in the background. It therefore cannot take dense traffic for long stretches. The sequencer counts how long it has been busy without a pause. When one more access would push that streak past a limit, it inserts a forced idle gap before it accepts anything else. After every access a recovery phase keeps all strobes inactive and the bus released, so the memory can let go of the data lines before the next cycle starts.

Top module: `psram_access_ctrl`

## Requirements
- R1: During and right after reset, select, write strobe, output strobe and both byte strobes are high, `req_ready` is 1, `rsp_done` is 0, `rsp_rdata` is 0 and the controller does not drive the bus.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle state. After a normal access it is 0 for ACC_CYC+HZ_CYC cycles, starting the cycle after acceptance.
- R3: `mem_cs_n` is low for exactly ACC_CYC consecutive cycles, beginning in the cycle after acceptance.
- R4: Byte mask bit 0 selects data bits 7:0 by driving `mem_lb_n` low. Bit 1 selects bits 15:8 by driving `mem_ub_n` low. Both only during the active phase. A mask of 00 leaves both strobes high, so no data moves and the stored word does not change.
- R5: During a read, `mem_oe_n` is low and `mem_we_n` is high for the whole active phase. The bus is sampled on the clock edge that ends the last active cycle.
- R6: `rsp_done` is high for exactly one cycle, the cycle after the last active cycle of every access. After a read, `rsp_rdata` holds the sampled word in that cycle, with unselected bytes forced to 0.
- R7: During a write, `mem_we_n` is low and `mem_oe_n` is high for the whole active phase. The controller drives the bus with the write data only in those cycles.
- R8: After each active phase, all strobes stay high and the bus stays undriven for at least HZ_CYC cycles before the next active phase.
- R9: The busy streak counts accepting-idle, active and recovery cycles. It resets on any idle cycle without a request, and on forced-gap cycles. At the end of recovery, if streak + (1+ACC_CYC+HZ_CYC) would exceed RUN_LIMIT, the controller stays unready for GAP_CYC extra cycles. The streak never exceeds RUN_LIMIT.
- R10: `mem_addr` and the driven write data keep the values latched at acceptance for the whole active phase, even if the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, unselected bytes zero |
| mem_addr | output | 20 | Memory address |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
Count from the accepting edge:
- The strobes fall in the next cycle and stay low for ACC_CYC cycles.
- `rsp_done` and the read word appear ACC_CYC+1 cycles after acceptance.
- `req_ready` returns after ACC_CYC+HZ_CYC cycles, or GAP_CYC cycles later when the streak limit forces a gap.

The bench keeps a cycle model that advances on each rising edge from the same inputs, and compares every pin against it on the falling edge, half a cycle after the registers settle. The memory model in the bench returns a poison value until ACC_CYC active cycles have passed, so a read sampled one cycle early is caught. A shadow array, updated only from the byte-mask rule, supplies the expected read data.

// File: rtl/psram_access_pkg.sv
package psram_access_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_RECOV = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_t;

  // True when one more full access would push the busy streak past the limit.
  function automatic logic gap_needed(input int streak_after, input int period, input int limit);
    return (streak_after + period) > limit;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/psram_run_guard.sv
module psram_run_guard
  import psram_access_pkg::*;
#(
  parameter int RUN_LIMIT = 200,
  parameter int PERIOD    = 18,
  parameter int RCW       = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           clear,
  output logic [RCW-1:0] run_cnt,
  output logic           gap_due
);
  always_ff @(posedge clk) begin
    if (!rst_n)                         run_cnt <= '0;
    else if (clear)                     run_cnt <= '0;
    else if (busy && run_cnt != '1)     run_cnt <= run_cnt + RCW'(1);
  end

  assign gap_due = gap_needed(int'(run_cnt) + 1, PERIOD, RUN_LIMIT);
endmodule

// File: rtl/psram_dq_lanes.sv
module psram_dq_lanes #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LANES-1:0]   lane_sel,
  input  logic [LANES*8-1:0] dq_in,
  output logic [LANES*8-1:0] rd_word
);
  logic [LANES*8-1:0] rd_next;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_next[l*8 +: 8] = lane_sel[l] ? dq_in[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_word <= '0;
    else if (capture) rd_word <= rd_next;
  end
endmodule

// File: rtl/psram_access_ctrl.sv
module psram_access_ctrl
  import psram_access_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ACC_CYC   = 14,
  parameter int HZ_CYC    = 3,
  parameter int GAP_CYC   = 4,
  parameter int RUN_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [15:0]       mem_dq,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n
);
  localparam int LANES  = 2;
  localparam int DQ_W   = LANES * 8;
  localparam int PERIOD = 1 + ACC_CYC + HZ_CYC;
  localparam int TCW    = $clog2(max3(ACC_CYC, HZ_CYC, GAP_CYC) + 1);
  localparam int RCW    = $clog2(RUN_LIMIT + PERIOD + 2);

  seq_state_t state, state_nx;

  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [LANES-1:0]  be_q;
  logic              wr_q;
  logic              done_q;

  logic           tmr_load;
  logic [TCW-1:0] tmr_val;
  logic           tmr_expire;

  // Named internal events
  logic           accept;
  logic           in_act;
  logic           act_end;
  logic           dq_drive;
  logic           run_busy;
  logic           run_clear;
  logic [RCW-1:0] run_cnt;
  logic           gap_due;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign in_act  = (state == ST_ACT);
  assign act_end = in_act && tmr_expire;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        state_nx = ST_ACT;
        tmr_load = 1'b1;
        tmr_val  = TCW'(ACC_CYC - 1);
      end
      ST_ACT: if (tmr_expire) begin
        state_nx = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = TCW'(HZ_CYC - 1);
      end
      ST_RECOV: if (tmr_expire) begin
        if (gap_due) begin
          state_nx = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TCW'(GAP_CYC - 1);
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_GAP: if (tmr_expire) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= act_end;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        wr_q    <= req_write;
      end
    end
  end

  psram_phase_timer #(.CW(TCW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  assign run_busy  = accept || in_act || (state == ST_RECOV);
  assign run_clear = ((state == ST_IDLE) && !req_valid) || (state == ST_GAP);

  psram_run_guard #(.RUN_LIMIT(RUN_LIMIT), .PERIOD(PERIOD), .RCW(RCW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (run_busy),
    .clear   (run_clear),
    .run_cnt (run_cnt),
    .gap_due (gap_due)
  );

  psram_dq_lanes #(.LANES(LANES)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (act_end && !wr_q),
    .lane_sel (be_q),
    .dq_in    (mem_dq),
    .rd_word  (rsp_rdata)
  );

  assign dq_drive  = in_act && wr_q;
  assign mem_dq    = dq_drive ? wdata_q : {DQ_W{1'bz}};

  assign req_ready = (state == ST_IDLE);
  assign rsp_done  = done_q;
  assign mem_addr  = addr_q;
  assign mem_cs_n  = !in_act;
  assign mem_we_n  = !(in_act && wr_q);
  assign mem_oe_n  = !(in_act && !wr_q);
  assign mem_lb_n  = !(in_act && be_q[0]);
  assign mem_ub_n  = !(in_act && be_q[1]);
endmodule

// File: rtl/psram_access_chk.sv
module psram_access_chk #(
  parameter int ADDR_W    = 20,
  parameter int ACC_CYC   = 14,
  parameter int HZ_CYC    = 3,
  parameter int RUN_LIMIT = 200,
  parameter int RCW       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              dq_drive,
  input logic [RCW-1:0]    run_cnt
);
  logic [15:0] lo_run;
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= 16'(HZ_CYC);
    end else if (!mem_cs_n) begin
      lo_run <= (lo_run != '1) ? lo_run + 16'd1 : lo_run;
      hi_run <= '0;
    end else begin
      lo_run <= '0;
      hi_run <= (hi_run != '1) ? hi_run + 16'd1 : hi_run;
    end
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);  // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_cs_n);  // R3
  AST_ACT_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (lo_run < 16'(ACC_CYC)));  // R3
  AST_ACT_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (lo_run == 16'(ACC_CYC)));  // R3
  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !dq_drive));  // R8
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));  // R7
  AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (!mem_cs_n && mem_oe_n));  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R6
  AST_DONE_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && lo_run == 16'(ACC_CYC)));  // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (hi_run >= 16'(HZ_CYC)));  // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_cnt) <= RUN_LIMIT);  // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && lo_run != 16'd0) |-> $stable(mem_addr));  // R10
endmodule

bind psram_access_ctrl psram_access_chk #(
  .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .HZ_CYC(HZ_CYC), .RUN_LIMIT(RUN_LIMIT), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .dq_drive(dq_drive), .run_cnt(run_cnt)
);

// File: tb/psram_access_ctrl_test.sv
`timescale 1ns/1ps
module psram_access_ctrl_test;
  localparam int ACC = 14, HZ = 3, GAP = 4, LIMIT = 200;
  localparam int PER = 1 + ACC + HZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_done, cs_n, we_n, oe_n, ub_n, lb_n;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  wire  [15:0] dq;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  psram_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(dq),
    .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n)
  );

  // ---------- memory model: poison until access time has passed ----------
  logic [15:0] mem [16];
  int rd_age = 0;
  logic rd_en;
  logic [3:0] ma;
  assign ma    = mem_addr[3:0];
  assign rd_en = !cs_n && !oe_n && we_n;
  assign dq[7:0]  = (rd_en && !lb_n) ? ((rd_age >= ACC) ? mem[ma][7:0]  : 8'hAD) : 8'hzz;
  assign dq[15:8] = (rd_en && !ub_n) ? ((rd_age >= ACC) ? mem[ma][15:8] : 8'hDE) : 8'hzz;

  always @(negedge clk) begin
    rd_age <= rd_en ? rd_age + 1 : 0;
    if (!cs_n && !we_n) begin
      if (!lb_n) mem[ma][7:0]  <= dq[7:0];
      if (!ub_n) mem[ma][15:8] <= dq[15:8];
    end
  end

  // ---------- reference model: shadow contents + cycle phases ----------
  logic [15:0] shadow [16];
  int ph = 0, left = 0, run = 0;
  bit m_done = 0, m_wr = 0;
  logic [1:0]  m_be = '0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_exp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; run = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (ph)
        0: if (req_valid) begin
             m_addr = req_addr; m_wr = req_write; m_be = req_be; m_wd = req_wdata;
             m_exp = {req_be[1] ? shadow[req_addr[3:0]][15:8] : 8'h00,
                      req_be[0] ? shadow[req_addr[3:0]][7:0]  : 8'h00};
             if (req_write) begin
               if (req_be[0]) shadow[req_addr[3:0]][7:0]  = req_wdata[7:0];
               if (req_be[1]) shadow[req_addr[3:0]][15:8] = req_wdata[15:8];
             end
             ph = 1; left = ACC; run = run + 1;
           end else run = 0;
        1: begin run++; left--; if (left == 0) begin ph = 2; left = HZ; m_done = 1; end end
        2: begin
             run++; left--;
             if (left == 0) begin
               if (run + PER > LIMIT) begin ph = 3; left = GAP; end else ph = 0;
             end
           end
        default: begin run = 0; left--; if (left == 0) ph = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // ---------- per-cycle comparison on the falling edge ----------
  always @(negedge clk) begin
    bit act;
    act = (ph == 1);
    chk(cs_n == !act, "R3 R8 cs_n", cs_n, !act);
    chk(oe_n == !(act && !m_wr), "R5 oe_n", oe_n, !(act && !m_wr));
    chk(we_n == !(act && m_wr), "R7 we_n", we_n, !(act && m_wr));
    chk(lb_n == !(act && m_be[0]), "R4 lb_n", lb_n, !(act && m_be[0]));
    chk(ub_n == !(act && m_be[1]), "R4 ub_n", ub_n, !(act && m_be[1]));
    chk(req_ready == (ph == 0), "R2 R9 req_ready", req_ready, ph == 0);
    chk(rsp_done == m_done, "R6 rsp_done", rsp_done, m_done);
    if (m_done && !m_wr) chk(rsp_rdata == m_exp, "R6 R4 rsp_rdata", rsp_rdata, m_exp);
    if (act) chk(mem_addr == m_addr, "R10 mem_addr", mem_addr, m_addr);
    if (act && m_wr) chk(dq == m_wd, "R7 R10 write data", dq, m_wd);
  end

  // ---------- gap observation ----------
  bit gap_win = 0;
  int low_run = 0, max_low = 0;
  always @(negedge clk) begin
    if (!req_ready) low_run++;
    else low_run = 0;
    if (gap_win && low_run > max_low) max_low = low_run;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R2 watchdog: actual cycles %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_be = ~be;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
      shadow[i] = mem[i];
    end
    idle(4);
    // R1: outputs during reset
    chk(cs_n && we_n && oe_n && ub_n && lb_n, "R1 strobes in reset", {cs_n, we_n, oe_n, ub_n, lb_n}, 5'h1F);
    chk(req_ready && !rsp_done && rsp_data_zero(), "R1 ready/done/rdata in reset", {req_ready, rsp_done}, 2'b10);
    rst_n = 1'b1;
    idle(2);
    chk(req_ready && cs_n && rsp_rdata == 16'h0, "R1 after reset", {req_ready, cs_n}, 2'b11);

    // writes with each mask value (R4, R7)
    req(1, 20'h00001, 16'h1234, 2'b11);
    req(1, 20'h00002, 16'h5678, 2'b01);
    req(1, 20'h00003, 16'h9ABC, 2'b10);
    req(1, 20'h00004, 16'hDEF0, 2'b00);
    idle(3);
    // reads back with various masks (R4, R5, R6)
    req(0, 20'h00001, 16'h0, 2'b11);
    req(0, 20'h00002, 16'h0, 2'b11);
    req(0, 20'h00003, 16'h0, 2'b11);
    req(0, 20'h00004, 16'h0, 2'b11);
    req(0, 20'h00005, 16'h0, 2'b01);
    req(0, 20'h00006, 16'h0, 2'b10);
    req(0, 20'h00007, 16'h0, 2'b00);
    idle(5);
    chk(mem[4] == shadow[4], "R4 mask 00 leaves word", mem[4], shadow[4]);

    // read/write alternation across turnaround (R8)
    req(0, 20'hABCD8, 16'h0, 2'b11);
    req(1, 20'hABCD8, 16'hC0DE, 2'b11);
    req(0, 20'hABCD8, 16'h0, 2'b11);
    idle(4);

    // streak limit forces a gap (R9)
    gap_win = 1;
    for (int k = 0; k < 12; k++) req(0, 20'(k), 16'h0, 2'b11);
    idle(40);
    gap_win = 0;
    chk(max_low == ACC + HZ + GAP, "R9 longest unready stretch", max_low, ACC + HZ + GAP);

    idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit rsp_data_zero();
    return rsp_rdata == 16'h0;
  endfunction
endmodule